// File: doc/BRIEF.md
# PLL Dynamic Phase-Step Sequencer

This block lives in core logic next to a PLL whose output counters can be nudged in phase one step at a time. A user hands it a request made of three things: a 5-bit code naming the output counter to adjust, a direction bit, and a number of steps. The sequencer then produces one low-to-high edge on the PLL's phase-enable line for each step. After every edge it waits for the PLL's done handshake before it starts the next step.

The whole block runs on the free-running scan clock that also feeds the PLL's phase-shift port. The PLL raises its done line on its own internal timing, so that line passes through a two-flop synchronizer first. Each step is counted as finished only after the synchronized done has been seen low and then high again.

The counter select and direction outputs are loaded when a request is accepted. They stay constant until the sequence ends, and each enable edge follows them by at least one cycle. If the PLL stops answering, a programmable wait limit ends the sequence and sets an error flag.

Top module: `pll_phase_stepper`

## Requirements
- R1: A request (`req_valid` high while `busy` is low) with a nonzero step count is accepted on that clock edge. From that edge on, `busy` is high, `ps_cntsel` equals `req_cnt_sel` and `ps_updn` equals `req_dir`. On `ps_updn`, 1 means a positive shift and 0 a negative one.
- R2: While `busy` stays high, `ps_cntsel` and `ps_updn` do not change. They have held their values for at least one full cycle before every rising edge of `ps_en`.
- R3: Each step is one rising edge of `ps_en`, and `ps_en` stays high for exactly two cycles. A request for N steps produces exactly N rising edges. `ps_en` is low whenever `busy` is low.
- R4: After each enable pulse, no further rising edge of `ps_en` appears until `ps_done` has gone low and then returned high.
- R5: After the handshake of the last step, `complete` is high for one cycle. In that same cycle `busy` is already low and `err` is low.
- R6: A request with a step count of 0 produces a one-cycle `complete` in the cycle right after acceptance. It produces no `ps_en` edge, and `busy` stays low.
- R7: A request presented while `busy` is high has no effect: the running sequence keeps its select code, direction and step count.
- R8: If the wait for `ps_done` lasts longer than `cfg_wait_limit` cycles, the sequence is abandoned. `err` goes high, `busy` goes low, `ps_en` stays low and no `complete` is produced.
- R9: `err` stays set until the next request is accepted, and it clears on that edge.
- R10: A request presented in the same cycle as `complete` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running scan clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled when idle |
| req_cnt_sel | input | 5 | Code of the output counter to adjust |
| req_dir | input | 1 | Shift direction: 1 positive, 0 negative |
| req_steps | input | 8 | Number of phase steps |
| cfg_wait_limit | input | 16 | Longest handshake wait, in cycles |
| busy | output | 1 | Sequence in progress |
| complete | output | 1 | One-cycle pulse when all steps are done |
| err | output | 1 | Sticky timeout flag |
| ps_en | output | 1 | Phase-step enable to the PLL |
| ps_updn | output | 1 | Direction to the PLL |
| ps_cntsel | output | 5 | Counter select to the PLL |
| ps_done | input | 1 | Step-done handshake from the PLL |

## Verification
Two functions meet in one cycle: the end of a sequence, where `complete` pulses and `busy` drops, and the acceptance of the next request. The bench watches for the `complete` pulse and presents a new request in that very cycle. It then requires `busy` to be high one cycle later and the new request's step count and select code to appear on the PLL side. The opposite boundary is also tested: a request given while the previous sequence is still busy must leave no trace in the edge count or the select code.

// File: rtl/pps_pkg.sv
package pps_pkg;
  typedef enum logic [2:0] {
    PS_IDLE  = 3'd0,
    PS_SETUP = 3'd1,
    PS_PULSE = 3'd2,
    PS_WLOW  = 3'd3,
    PS_WHIGH = 3'd4
  } pps_state_e;
endpackage

// File: rtl/pps_sync2.sv
module pps_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pps_wait_timer.sv
module pps_wait_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         expired
);
  logic [W-1:0] cnt;

  function automatic logic over_limit(input logic [W-1:0] c, input logic [W-1:0] l);
    return c >= l;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (!run)            cnt <= '0;
    else if (cnt != '1)       cnt <= cnt + 1'b1;
  end

  assign expired = run && over_limit(cnt, limit);
endmodule

// File: rtl/pps_step_ctr.sv
module pps_step_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         last
);
  logic [W-1:0] remaining;

  function automatic logic [W-1:0] step_down(input logic [W-1:0] r);
    return (r == '0) ? r : r - 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    remaining <= '0;
    else if (load) remaining <= load_val;
    else if (dec)  remaining <= step_down(remaining);
  end

  assign last = (remaining == {{(W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/pll_phase_stepper.sv
module pll_phase_stepper
  import pps_pkg::*;
#(
  parameter int SEL_W     = 5,
  parameter int STEP_W    = 8,
  parameter int TO_W      = 16,
  parameter int PULSE_CYC = 2,
  parameter int SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [SEL_W-1:0]  req_cnt_sel,
  input  logic              req_dir,
  input  logic [STEP_W-1:0] req_steps,
  input  logic [TO_W-1:0]   cfg_wait_limit,
  output logic              busy,
  output logic              complete,
  output logic              err,
  output logic              ps_en,
  output logic              ps_updn,
  output logic [SEL_W-1:0]  ps_cntsel,
  input  logic              ps_done
);
  localparam int PC_W = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;

  pps_state_e state, nxt;
  logic [PC_W-1:0]  pulse_cnt;
  logic [SEL_W-1:0] sel_q;
  logic             dir_q, en_q, busy_q, cmpl_q, err_q;

  // named internal events
  logic done_s, expired, last_step;
  logic accept, zero_req, step_fin, tmo_abort, pulse_end, waiting;

  pps_sync2 #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ps_done), .q(done_s)
  );

  assign waiting = (state == PS_WLOW) || (state == PS_WHIGH);

  pps_wait_timer #(.W(TO_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(waiting), .limit(cfg_wait_limit), .expired(expired)
  );

  assign accept    = req_valid && (state == PS_IDLE);
  assign zero_req  = accept && (req_steps == '0);
  assign step_fin  = (state == PS_WHIGH) && done_s;
  assign tmo_abort = expired && ((state == PS_WLOW) || ((state == PS_WHIGH) && !done_s));
  assign pulse_end = (state == PS_PULSE) && (pulse_cnt == PC_W'(PULSE_CYC - 1));

  pps_step_ctr #(.W(STEP_W)) u_steps (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(req_steps),
    .dec(step_fin), .last(last_step)
  );

  always_comb begin
    nxt = state;
    unique case (state)
      PS_IDLE:  if (accept && !zero_req) nxt = PS_SETUP;
      PS_SETUP: nxt = PS_PULSE;
      PS_PULSE: if (pulse_end) nxt = PS_WLOW;
      PS_WLOW:  if (tmo_abort) nxt = PS_IDLE;
                else if (!done_s) nxt = PS_WHIGH;
      PS_WHIGH: if (tmo_abort) nxt = PS_IDLE;
                else if (step_fin) nxt = last_step ? PS_IDLE : PS_SETUP;
      default:  nxt = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= PS_IDLE;
      pulse_cnt <= '0;
      en_q      <= 1'b0;
      sel_q     <= '0;
      dir_q     <= 1'b0;
      busy_q    <= 1'b0;
      cmpl_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      state     <= nxt;
      pulse_cnt <= (state == PS_PULSE) ? pulse_cnt + 1'b1 : '0;
      en_q      <= (nxt == PS_PULSE);
      cmpl_q    <= zero_req || (step_fin && last_step);
      if (accept) begin
        sel_q <= req_cnt_sel;
        dir_q <= req_dir;
      end
      if (accept && !zero_req)                   busy_q <= 1'b1;
      else if ((step_fin && last_step) || tmo_abort) busy_q <= 1'b0;
      if (accept)         err_q <= 1'b0;
      else if (tmo_abort) err_q <= 1'b1;
    end
  end

  assign busy      = busy_q;
  assign complete  = cmpl_q;
  assign err       = err_q;
  assign ps_en     = en_q;
  assign ps_updn   = dir_q;
  assign ps_cntsel = sel_q;
endmodule

// File: rtl/pps_checker.sv
module pps_checker #(
  parameter int SEL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             complete,
  input logic             err,
  input logic             ps_en,
  input logic             ps_updn,
  input logic [SEL_W-1:0] ps_cntsel,
  input logic             tmo_abort,
  input logic             step_fin
);
  // R3: enable stays high for a second cycle after rising
  a_r3_en_second_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ps_en) |=> ps_en);
  // R3: enable never lasts beyond two cycles
  a_r3_en_two_max: assert property (@(posedge clk) disable iff (!rst_n)
    (ps_en && $past(ps_en)) |=> !ps_en);
  // R3: enable only during a sequence
  a_r3_en_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ps_en |-> busy);
  // R2: select and direction frozen while busy persists
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(ps_updn) && $stable(ps_cntsel)));
  // R5: completion reported with busy low and no error
  a_r5_complete_clean: assert property (@(posedge clk) disable iff (!rst_n)
    complete |-> (!busy && !err));
  // R8: a timeout ends the sequence with the error flag
  a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_abort |=> (err && !busy && !complete && !ps_en));
  // R4: a finished step never coincides with a timeout
  a_r4_fin_vs_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_fin && tmo_abort));
endmodule

bind pll_phase_stepper pps_checker #(.SEL_W(SEL_W)) u_pps_checker (
  .clk(clk), .rst_n(rst_n), .busy(busy), .complete(complete), .err(err),
  .ps_en(ps_en), .ps_updn(ps_updn), .ps_cntsel(ps_cntsel),
  .tmo_abort(tmo_abort), .step_fin(step_fin)
);

// File: tb/pll_phase_stepper_bench.sv
module pll_phase_stepper_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [4:0] req_cnt_sel = '0;
  logic       req_dir = 1'b0;
  logic [7:0] req_steps = '0;
  logic [15:0] cfg_wait_limit = 16'd40;
  logic busy, complete, err, ps_en, ps_updn;
  logic [4:0] ps_cntsel;
  logic pll_done = 1'b1;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // responder and monitor state
  logic       en_d = 1'b0;
  bit         pending = 0;
  bit         dead = 0;
  int         dly = 0;
  int         resp_dly = 4;
  int         rises = 0;
  int         mism = 0;
  int         early = 0;
  logic [4:0] exp_sel = '0;
  logic       exp_dir = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_phase_stepper u_pll_phase_stepper (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cnt_sel(req_cnt_sel),
    .req_dir(req_dir), .req_steps(req_steps), .cfg_wait_limit(cfg_wait_limit),
    .busy(busy), .complete(complete), .err(err), .ps_en(ps_en),
    .ps_updn(ps_updn), .ps_cntsel(ps_cntsel), .ps_done(pll_done)
  );

  // behavioural PLL responder plus edge monitor
  always @(negedge clk) begin
    en_d <= ps_en;
    if (ps_en && !en_d) begin
      rises <= rises + 1;
      if (pending) early <= early + 1;
      if (ps_cntsel !== exp_sel || ps_updn !== exp_dir) mism <= mism + 1;
      pending  <= 1;
      pll_done <= 1'b0;
      dly      <= resp_dly;
    end else if (pending) begin
      if (ps_cntsel !== exp_sel || ps_updn !== exp_dir) mism <= mism + 1;
      if (dly > 0) dly <= dly - 1;
      else if (!dead) begin
        pll_done <= 1'b1;
        pending  <= 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic [4:0] sel, input logic dir, input logic [7:0] n);
    @(negedge clk);
    req_valid = 1'b1; req_cnt_sel = sel; req_dir = dir; req_steps = n;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_complete(input int maxc, output bit got);
    got = 0;
    for (int i = 0; i < maxc; i++) begin
      if (complete) begin got = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk(busy == 0 && ps_en == 0 && complete == 0 && err == 0, "R1 reset idle",
        {busy, ps_en, complete, err}, 0);
  endtask

  task automatic t_run(input logic [4:0] sel, input logic dir, input logic [7:0] n, input int d);
    bit got;
    int r0 = rises, m0 = mism, e0 = early;
    resp_dly = d; exp_sel = sel; exp_dir = dir;
    issue(sel, dir, n);
    chk(busy == 1, "R1 busy after accept", busy, 1);
    chk(ps_cntsel == sel && ps_updn == dir, "R1 select/direction loaded", ps_cntsel, sel);
    chk(err == 0, "R9 error cleared on accept", err, 0);
    wait_complete(3000, got);
    chk(got, "R5 complete seen", got, 1);
    chk(busy == 0 && err == 0, "R5 busy/err low at complete", {busy, err}, 0);
    @(negedge clk);
    chk(complete == 0, "R5 complete one cycle", complete, 0);
    chk(rises - r0 == n, "R3 edge count", rises - r0, n);
    chk(mism == m0, "R2 select/direction stable", mism - m0, 0);
    chk(early == e0, "R4 no edge before handshake", early - e0, 0);
  endtask

  task automatic t_zero();
    int r0 = rises;
    issue(5'd3, 1'b1, 8'd0);
    chk(complete == 1 && busy == 0, "R6 zero-step complete", {complete, busy}, 2);
    @(negedge clk);
    chk(complete == 0, "R6 single pulse", complete, 0);
    repeat (4) @(negedge clk);
    chk(rises == r0 && busy == 0, "R6 no enable edge", rises - r0, 0);
  endtask

  task automatic t_ignore();
    bit got;
    int r0 = rises;
    resp_dly = 6; exp_sel = 5'd5; exp_dir = 1'b0;
    issue(5'd5, 1'b0, 8'd3);
    repeat (3) @(negedge clk);
    issue(5'd9, 1'b1, 8'd6);
    chk(ps_cntsel == 5'd5 && ps_updn == 1'b0, "R7 busy request ignored (select)", ps_cntsel, 5);
    wait_complete(3000, got);
    chk(got && rises - r0 == 3, "R7 busy request ignored (steps)", rises - r0, 3);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_b2b();
    bit got;
    int r0;
    resp_dly = 3; exp_sel = 5'd17; exp_dir = 1'b1;
    issue(5'd17, 1'b1, 8'd2);
    wait_complete(3000, got);
    r0 = rises;
    exp_sel = 5'd30; exp_dir = 1'b0;
    req_valid = 1'b1; req_cnt_sel = 5'd30; req_dir = 1'b0; req_steps = 8'd2;
    @(negedge clk);
    req_valid = 1'b0;
    chk(got && busy == 1 && ps_cntsel == 5'd30, "R10 accept in complete cycle", ps_cntsel, 30);
    wait_complete(3000, got);
    chk(got && rises - r0 == 2, "R10 second sequence steps", rises - r0, 2);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_timeout();
    bit seen_cmpl = 0;
    bit dropped = 0;
    resp_dly = 2; dead = 1; exp_sel = 5'd1; exp_dir = 1'b1;
    cfg_wait_limit = 16'd20;
    issue(5'd1, 1'b1, 8'd4);
    for (int i = 0; i < 60; i++) begin
      if (complete) seen_cmpl = 1;
      if (!busy) begin dropped = 1; break; end
      @(negedge clk);
    end
    chk(dropped && err == 1, "R8 timeout raises err", err, 1);
    chk(!seen_cmpl && ps_en == 0, "R8 no complete on abort", seen_cmpl, 0);
    repeat (5) @(negedge clk);
    chk(err == 1, "R9 err sticky", err, 1);
    dead = 0;
    repeat (8) @(negedge clk);
    cfg_wait_limit = 16'd40;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_run(5'd2, 1'b1, 8'd1, 3);
    t_run(5'd12, 1'b0, 8'd5, 5);
    t_run(5'd31, 1'b1, 8'd3, 0);
    t_zero();
    t_ignore();
    t_b2b();
    t_timeout();
    t_run(5'd7, 1'b0, 8'd2, 4);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule